// File: doc/BRIEF.md
# Secondary Bus Arbiter with Grant Parking

This block decides which agent owns a shared PCI-style secondary bus. Nine external masters raise active-low request lines and receive active-low grant lines. The bridge itself is a tenth agent. Its request and grant are internal, active-high signals. The arbiter watches the bus `frame_n` and `irdy_n` lines. Grant hand-offs therefore happen only when the current transaction can no longer be cut short. Between competing requesters, ownership rotates round-robin.

When nobody is requesting, one agent is kept granted (parked). The parked agent is the one that most recently drove a transaction. A configuration bit can instead force parking at the bridge. After reset the bus is parked at the bridge, because the bridge counts as the last owner until real traffic appears.

With `arb_en` low, an outside arbiter owns the bus and this block stops arbitrating. In that mode request line 0 becomes the bridge's incoming grant. Grant line 0 carries the bridge's own request out to the outside arbiter. All other grants stay deasserted.

None of the pins here carry a data stream, so there is no valid/ready handshake; every pin is plain control.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `gnt_n` line is 1, `bridge_gnt` is 1, `bridge_park` is 0, and the park-at-bridge configuration bit is 0.
- R2: With `arb_en` high in the current and previous cycle, at most one of {the nine grants low, `bridge_gnt` high} is active in any cycle.
- R3: When the granted agent changes, the old grant drops at one rising edge. The new grant asserts at the next edge, leaving exactly one cycle with no grant.
- R4: A grant is never removed at an edge where `frame_n` is sampled low. Removal needs `frame_n` high, which means the bus is idle (`irdy_n` high) or in its last data phase (`irdy_n` low).
- R5: Among pending requests, the winner is the first requester found by scanning agent indices upward, wrapping around, starting just after the last owner. Indices 0 to 8 are external lines `req_n[0]` to `req_n[8]`; index 9 is the bridge.
- R6: The last owner is the agent holding the grant at the most recent edge where `frame_n` was sampled low. With no requests pending and the configuration bit clear, the grant parks on that agent.
- R7: Until the first edge with `frame_n` low while a grant is held, the last owner is the bridge, so an idle bus stays parked at the bridge.
- R8: An edge with `cfg_we` high loads `cfg_park_bridge` into the configuration bit. While that bit is 1 and no request is pending, the grant parks at the bridge whatever the last owner was.
- R9: An edge with `arb_en` low clears all internal grants. One cycle later, three outputs follow the inputs sampled at that edge: `gnt_n[0]` equals the inverted `bridge_req`, `bridge_gnt` equals the inverted `req_n[0]`, and `bridge_park` is high only if `req_n[0]` was low and both `frame_n` and `irdy_n` were high.
- R10: The bridge takes part in the rotation like any external master. A granted bridge sees `bridge_gnt` high in the cycle before it may drive `frame_n`.
- R11: A grant holder keeps its grant while no other agent requests, whether or not it is still requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | 1: internal arbitration; 0: outside arbiter mode |
| cfg_we | input | 1 | Load strobe for the park-at-bridge bit |
| cfg_park_bridge | input | 1 | Value loaded into the park-at-bridge bit |
| req_n | input | N_EXT | Active-low external requests; bit 0 is the bridge grant in outside mode |
| bridge_req | input | 1 | Bridge wants the bus (active high) |
| frame_n | input | 1 | Bus frame, active low |
| irdy_n | input | 1 | Bus initiator ready, active low |
| gnt_n | output | N_EXT | Active-low external grants; bit 0 is the bridge request in outside mode |
| bridge_gnt | output | 1 | Bridge owns or is parked on the bus |
| bridge_park | output | 1 | Outside mode: bridge granted and bus was idle |

## Verification
A corrupted last-owner register shows up at the ports as a wrong parked grant or a wrong round-robin winner. This appears within two cycles of the bus going idle or of two requests colliding. A grant register that breaks its one-hot or break-before-make rule shows as two low grant lines, or as a direct switch with no empty cycle, on the very next edge. A mode register that lags shows as grant line 0 or `bridge_gnt` one cycle out of step with the inputs of the outside arbiter mode.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int SBA_EXT_DEFAULT = 9;

  typedef enum logic {
    ARB_OUTSIDE = 1'b0,
    ARB_INSIDE  = 1'b1
  } sba_mode_e;
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
  parameter  int NA = 10,
  localparam int AW = $clog2(NA)
) (
  input  logic [NA-1:0] req,
  input  logic [AW-1:0] last,
  output logic          hit,
  output logic [AW-1:0] win
);
  logic [AW-1:0] cand [NA];

  // candidate k is the agent k+1 places after the last owner
  for (genvar k = 0; k < NA; k++) begin : g_cand
    assign cand[k] = AW'((int'(last) + 1 + k) % NA);
  end

  always_comb begin
    hit = 1'b0;
    win = last;
    for (int k = NA - 1; k >= 0; k--) begin
      if (req[cand[k]]) begin
        hit = 1'b1;
        win = cand[k];
      end
    end
  end
endmodule

// File: rtl/sba_park_policy.sv
module sba_park_policy #(
  parameter  int NA = 10,
  localparam int AW = $clog2(NA),
  localparam logic [AW-1:0] BR = AW'(NA - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arb_en,
  input  logic          frame_n,
  input  logic [NA-1:0] gnt_q,
  input  logic          cfg_we,
  input  logic          cfg_park_bridge,
  output logic [AW-1:0] last_owner,
  output logic [AW-1:0] park_idx
);
  logic          park_cfg_q;
  logic [AW-1:0] last_q;
  logic [AW-1:0] holder_idx;

  always_comb begin
    holder_idx = '0;
    for (int i = 0; i < NA; i++) begin
      if (gnt_q[i]) holder_idx = holder_idx | AW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_cfg_q <= 1'b0;
      last_q     <= BR;
    end else begin
      if (cfg_we) park_cfg_q <= cfg_park_bridge;
      if (arb_en && !frame_n && (|gnt_q)) last_q <= holder_idx;
    end
  end

  assign last_owner = last_q;
  assign park_idx   = park_cfg_q ? BR : last_q;

  // R6 / R7: ownership history only moves on a busy-bus edge
  assert_owner_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q != $past(last_q)) |-> !$past(frame_n));

  // R8: configuration bit holds without a write strobe
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(park_cfg_q));
endmodule

// File: rtl/sba_grant_ctrl.sv
module sba_grant_ctrl #(
  parameter  int NA = 10,
  localparam int AW = $clog2(NA),
  localparam logic [AW-1:0] BR = AW'(NA - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arb_en,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          req_n0,
  input  logic          bridge_req,
  input  logic          hit,
  input  logic [AW-1:0] win,
  input  logic [AW-1:0] park_idx,
  output logic [NA-1:0] gnt_q,
  output logic          xgnt_q,
  output logic          xpark_q,
  output logic          xbreq_q
);
  sba_pkg::sba_mode_e mode;
  logic [AW-1:0]      target;
  logic [NA-1:0]      gnt_d;

  assign mode   = arb_en ? sba_pkg::ARB_INSIDE : sba_pkg::ARB_OUTSIDE;
  assign target = hit ? win : park_idx;

  always_comb begin
    gnt_d = gnt_q;
    if (mode == sba_pkg::ARB_OUTSIDE) begin
      gnt_d = '0;
    end else if (gnt_q == '0) begin
      gnt_d = NA'(1) << target;
    end else if (!gnt_q[target] && frame_n) begin
      gnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q   <= NA'(1) << BR;
      xgnt_q  <= 1'b0;
      xpark_q <= 1'b0;
      xbreq_q <= 1'b0;
    end else begin
      gnt_q   <= gnt_d;
      xgnt_q  <= (mode == sba_pkg::ARB_OUTSIDE) && !req_n0;
      xpark_q <= (mode == sba_pkg::ARB_OUTSIDE) && !req_n0 && frame_n && irdy_n;
      xbreq_q <= (mode == sba_pkg::ARB_OUTSIDE) && bridge_req;
    end
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  assert_break_before_make_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_q) |=> (gnt_q == '0) || (gnt_q == $past(gnt_q)));

  assert_no_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && !frame_n && (|gnt_q)) |=> (gnt_q == $past(gnt_q)));

  assert_outside_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (gnt_q == '0));
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter #(
  parameter  int N_EXT = sba_pkg::SBA_EXT_DEFAULT,
  localparam int NA    = N_EXT + 1,
  localparam int AW    = $clog2(NA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_en,
  input  logic             cfg_we,
  input  logic             cfg_park_bridge,
  input  logic [N_EXT-1:0] req_n,
  input  logic             bridge_req,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic [N_EXT-1:0] gnt_n,
  output logic             bridge_gnt,
  output logic             bridge_park
);
  logic [NA-1:0] req_vec;
  logic [NA-1:0] gnt_q;
  logic [AW-1:0] last_owner;
  logic [AW-1:0] park_idx;
  logic [AW-1:0] win;
  logic          hit;
  logic          xgnt_q;
  logic          xpark_q;
  logic          xbreq_q;

  assign req_vec = {bridge_req, ~req_n};

  sba_rr_pick #(.NA(NA)) u_pick (
    .req  (req_vec),
    .last (last_owner),
    .hit  (hit),
    .win  (win)
  );

  sba_park_policy #(.NA(NA)) u_park (
    .clk             (clk),
    .rst_n           (rst_n),
    .arb_en          (arb_en),
    .frame_n         (frame_n),
    .gnt_q           (gnt_q),
    .cfg_we          (cfg_we),
    .cfg_park_bridge (cfg_park_bridge),
    .last_owner      (last_owner),
    .park_idx        (park_idx)
  );

  sba_grant_ctrl #(.NA(NA)) u_gnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_en     (arb_en),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .req_n0     (req_n[0]),
    .bridge_req (bridge_req),
    .hit        (hit),
    .win        (win),
    .park_idx   (park_idx),
    .gnt_q      (gnt_q),
    .xgnt_q     (xgnt_q),
    .xpark_q    (xpark_q),
    .xbreq_q    (xbreq_q)
  );

  assign gnt_n       = ~(gnt_q[N_EXT-1:0] | {{(N_EXT-1){1'b0}}, xbreq_q});
  assign bridge_gnt  = gnt_q[N_EXT] | xgnt_q;
  assign bridge_park = xpark_q;

  assert_port_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && $past(arb_en)) |-> $onehot0({~gnt_n, bridge_gnt}));

  assert_outside_bridge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (bridge_gnt == !$past(req_n[0])));
endmodule

// File: tb/sim_sec_bus_arbiter.sv
module sim_sec_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 9;
  localparam int BRIDGE = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arb_en = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_park_bridge = 1'b0;
  logic [NE-1:0] req_n = '1;
  logic          bridge_req = 1'b0;
  logic          frame_n = 1'b1;
  logic          irdy_n = 1'b1;
  logic [NE-1:0] gnt_n;
  logic          bridge_gnt;
  logic          bridge_park;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  // reference model state
  int  m_gnt, m_last;
  bit  m_cfg, m_xg, m_xp, m_xb;
  // bus agent
  bit  auto_bus = 1'b0;
  int  tx_len = 2;
  int  tx_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_bus_arbiter #(.N_EXT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .cfg_we(cfg_we),
    .cfg_park_bridge(cfg_park_bridge), .req_n(req_n), .bridge_req(bridge_req),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n),
    .bridge_gnt(bridge_gnt), .bridge_park(bridge_park)
  );

  function automatic bit req_on(int a);
    return (a == BRIDGE) ? bridge_req : !req_n[a];
  endfunction

  task automatic model_reset();
    m_gnt = BRIDGE; m_last = BRIDGE; m_cfg = 0;
    m_xg = 0; m_xp = 0; m_xb = 0;
  endtask

  task automatic check(string tag, bit ok, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [NE-1:0] eg;
    bit eb;
    for (int i = 0; i < NE; i++) eg[i] = !((m_gnt == i) || (i == 0 && m_xb));
    eb = (m_gnt == BRIDGE) || m_xg;
    check(tag, {gnt_n, bridge_gnt, bridge_park} == {eg, eb, m_xp},
          "gnt_n/bridge_gnt/bridge_park",
          int'({gnt_n, bridge_gnt, bridge_park}), int'({eg, eb, m_xp}));
  endtask

  // one clock: bus agent, model step, edge, compare away from the edge
  task automatic step(string tag);
    int tgt, nxt;
    bit any;
    if (auto_bus) begin
      if (tx_cnt == 0 && m_gnt >= 0 && req_on(m_gnt)) tx_cnt = tx_len;
      if (tx_cnt > 0) begin
        frame_n = (tx_cnt == 1); irdy_n = 1'b0; tx_cnt--;
      end else begin
        frame_n = 1'b1; irdy_n = 1'b1;
      end
    end
    any = 0; tgt = 0;
    for (int k = 1; k <= 10 && !any; k++) begin
      if (req_on((m_last + k) % 10)) begin any = 1; tgt = (m_last + k) % 10; end
    end
    if (!any) tgt = m_cfg ? BRIDGE : m_last;
    if (!arb_en) nxt = -1;
    else if (m_gnt == -1) nxt = tgt;
    else if (m_gnt != tgt && frame_n) nxt = -1;
    else nxt = m_gnt;
    @(posedge clk);
    if (arb_en && !frame_n && m_gnt >= 0) m_last = m_gnt;
    if (cfg_we) m_cfg = cfg_park_bridge;
    m_xg = !arb_en && !req_n[0];
    m_xp = m_xg && frame_n && irdy_n;
    m_xb = !arb_en && bridge_req;
    m_gnt = nxt;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_reqs(logic [9:0] r);
    req_n = ~r[8:0];
    bridge_req = r[9];
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    check("R1", gnt_n == '1 && bridge_gnt && !bridge_park, "reset outputs",
          int'({gnt_n, bridge_gnt, bridge_park}), int'({9'h1ff, 1'b1, 1'b0}));

    // R7: idle bus stays with the bridge
    repeat (4) step("R7");
    check("R7", bridge_gnt == 1'b1, "bridge parked", int'(bridge_gnt), 1);

    // R5 / R10: rotation among 3, 7 and bridge with short transactions
    auto_bus = 1'b1; tx_len = 2;
    set_reqs(10'b10_1000_1000);
    repeat (6) step("R5");
    repeat (30) step("R10");

    // R4: long transaction by agent 2 while agent 6 waits
    set_reqs(10'b00_0000_0100);
    repeat (6) step("R4");
    tx_len = 6;
    set_reqs(10'b00_0100_0100);
    repeat (20) step("R4");

    // R3: hand-off sequences across several pairs
    tx_len = 3;
    set_reqs(10'b00_1010_0001);
    repeat (30) step("R3");

    // R6: agent 5 uses the bus, then everybody goes quiet
    tx_len = 2;
    set_reqs(10'b00_0010_0000);
    repeat (8) step("R6");
    set_reqs('0);
    repeat (6) step("R6");
    check("R6", gnt_n == ~9'b0_0010_0000, "parked at 5", int'(gnt_n), int'(~9'b0_0010_0000 & 9'h1ff));

    // R11: agent 4 alone, keeps grant with and without requesting
    set_reqs(10'b00_0001_0000);
    repeat (10) step("R11");
    auto_bus = 1'b0; frame_n = 1'b1; irdy_n = 1'b1;
    set_reqs('0);
    repeat (5) step("R11");

    // R8: force park at the bridge, then clear
    cfg_we = 1'b1; cfg_park_bridge = 1'b1;
    step("R8");
    cfg_we = 1'b0;
    repeat (4) step("R8");
    check("R8", bridge_gnt && gnt_n == '1, "forced bridge park",
          int'({gnt_n, bridge_gnt}), int'({9'h1ff, 1'b1}));
    cfg_we = 1'b1; cfg_park_bridge = 1'b0;
    step("R8");
    cfg_we = 1'b0;
    repeat (4) step("R8");

    // R9: outside arbiter mode
    arb_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      req_n = 9'($urandom); bridge_req = 1'($urandom);
      frame_n = 1'($urandom); irdy_n = 1'($urandom);
      step("R9");
    end
    arb_en = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; set_reqs('0);
    repeat (4) step("R9");

    // R2: random mix with bus agent and occasional config writes
    auto_bus = 1'b1; tx_cnt = 0;
    for (int i = 0; i < 600; i++) begin
      if (i % 7 == 0) set_reqs(10'($urandom));
      tx_len = 2 + int'($urandom % 4);
      cfg_we = ($urandom % 50) == 0;
      cfg_park_bridge = 1'($urandom);
      step("R2");
      if (arb_en)
        check("R2", $countones({~gnt_n, bridge_gnt}) <= 1, "grant count",
              $countones({~gnt_n, bridge_gnt}), 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule